// File: doc/BRIEF.md
# Superpriority Interrupt Masking Arbiter

This unit sits in a processor core between the interrupt request lines and the exception entry logic. Six level-sensitive request lines arrive: physical IRQ, FIQ and NMI, and their three virtual counterparts. For each line the core supplies the exception level that line targets. The unit combines these with the current exception level, the per-level control bits (superpriority enable and stack-select interrupt-mask enable) and the status bits I, F, ALLINT and SP. From these it decides which pending request, if any, is taken.

Superpriority (NMI-class) requests ignore the classic I and F masks once their target level enables superpriority. They can still be held off by the all-interrupt mask or the stack-select mask, but only when the request targets the level that is executing now. The winner is reported as a registered exception kind and target level, with a one-cycle take strobe each time a new winner appears. A registered wake flag tells the power logic that the core has something to do.

Top module: `irq_superprio_arb`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `take_o`, `kind_o`, `tgt_o` and `has_work_o` are all zero.
- R2: Request bit index is 0=IRQ, 1=FIQ, 2=VIRQ, 3=VFIQ, 4=NMI, 5=VNMI. The target level of line k is `line_tgt_i[2k+1:2k]`. `kind_o` encodes 0=none, 1=NMI, 2=FIQ, 3=IRQ, 4=VNMI, 5=VFIQ, 6=VIRQ.
- R3: A request whose target level is below `cur_lvl_i` is never chosen.
- R4: A request is blocked by the all-interrupt mask when `st_allint_i` is 1, its target level equals `cur_lvl_i`, and bit [target] of `nmi_en_i` is 1. Otherwise ALLINT has no effect.
- R5: A request is blocked by the stack-select mask when `st_sp_i` is 1, its target equals `cur_lvl_i`, and bits [target] of both `nmi_en_i` and `spmask_en_i` are 1. Otherwise SP has no effect.
- R6: NMI and VNMI are unmasked when no R4/R5 block applies. If bit [target] of `nmi_en_i` is 1, they ignore I and F. If it is 0, they are masked by I exactly like an ordinary IRQ.
- R7: FIQ and VFIQ need `st_f_i`=0. IRQ and VIRQ need `st_i_i`=0. Each of the four also needs no R4/R5 block.
- R8: Among unmasked requests the order is NMI, VNMI, FIQ, IRQ, VFIQ, VIRQ. The first one in this order wins.
- R9: `kind_o` shows the winner for the inputs of the previous cycle, or 0 when there is none. `take_o` is high for exactly that cycle when `kind_o` is nonzero and differs from its value one cycle earlier.
- R10: `has_work_o` equals, one cycle late, (`pwr_off_i`=0) and (any request bit or `vserr_i` set).
- R11: `tgt_o` shows the target level of the winning line, one cycle late, and is 0 when there is no winner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 6 | Level-sensitive request lines (R2 index order) |
| vserr_i | input | 1 | Virtual SError pending, used for the wake flag only |
| pwr_off_i | input | 1 | Core is powered off |
| cur_lvl_i | input | LVL_W | Current exception level |
| line_tgt_i | input | 6*LVL_W | Per-line target level |
| nmi_en_i | input | 2**LVL_W | Superpriority enable, one bit per level |
| spmask_en_i | input | 2**LVL_W | Stack-select mask enable, one bit per level |
| st_i_i | input | 1 | Status I mask |
| st_f_i | input | 1 | Status F mask |
| st_allint_i | input | 1 | Status all-interrupt mask |
| st_sp_i | input | 1 | Status stack-select bit |
| take_o | output | 1 | One-cycle pulse when a new winner appears |
| kind_o | output | 3 | Encoded winning exception kind |
| tgt_o | output | LVL_W | Target level of the winner |
| has_work_o | output | 1 | Wake flag |

## Verification
The bench sweeps every combination of request lines, current level and status bits. It does this under four target and control patterns, so that same-level, higher-level and lower-level targets all occur with the superpriority and stack-mask bits in mixed states. This catches a design that applies ALLINT or SP to a request aimed at a different level: it would drop NMIs that should be taken. It also catches a design that lets I mask an NMI whose level enables superpriority, or fails to when the level does not. A swapped priority, such as FIQ ahead of VNMI, shows up as a wrong kind. Each step compares the previous winner with the new one, so a take strobe that stays high for a persistent request, or stays low when the winner changes, is caught.

// File: rtl/irqarb_pkg.sv
package irqarb_pkg;
  localparam int NLINES = 6;

  // request bit positions
  localparam int LN_IRQ  = 0;
  localparam int LN_FIQ  = 1;
  localparam int LN_VIRQ = 2;
  localparam int LN_VFIQ = 3;
  localparam int LN_NMI  = 4;
  localparam int LN_VNMI = 5;

  typedef enum logic [2:0] {
    K_NONE = 3'd0,
    K_NMI  = 3'd1,
    K_FIQ  = 3'd2,
    K_IRQ  = 3'd3,
    K_VNMI = 3'd4,
    K_VFIQ = 3'd5,
    K_VIRQ = 3'd6
  } kind_e;

  // line considered at a given rank (rank 0 wins)
  function automatic int line_at_rank(input int rank);
    case (rank)
      0: return LN_NMI;
      1: return LN_VNMI;
      2: return LN_FIQ;
      3: return LN_IRQ;
      4: return LN_VFIQ;
      default: return LN_VIRQ;
    endcase
  endfunction

  function automatic kind_e kind_of_line(input int ln);
    case (ln)
      LN_NMI:  return K_NMI;
      LN_VNMI: return K_VNMI;
      LN_FIQ:  return K_FIQ;
      LN_IRQ:  return K_IRQ;
      LN_VFIQ: return K_VFIQ;
      default: return K_VIRQ;
    endcase
  endfunction

  function automatic bit line_is_super(input int ln);
    return (ln == LN_NMI) || (ln == LN_VNMI);
  endfunction

  function automatic bit line_uses_f(input int ln);
    return (ln == LN_FIQ) || (ln == LN_VFIQ);
  endfunction
endpackage

// File: rtl/irqarb_gate.sv
module irqarb_gate #(
  parameter int LVL_W    = 2,
  parameter bit IS_SUPER = 1'b0,
  parameter bit USE_F    = 1'b0
) (
  input  logic             pend,
  input  logic [LVL_W-1:0] cur,
  input  logic [LVL_W-1:0] tgt,
  input  logic             nmi_en,
  input  logic             spm_en,
  input  logic             st_i,
  input  logic             st_f,
  input  logic             st_allint,
  input  logic             st_sp,
  output logic             ok
);
  logic same_lvl, reachable, blk_all, blk_sp, free_of_super;

  always_comb begin
    same_lvl      = (tgt == cur);
    reachable     = (tgt >= cur);
    blk_all       = nmi_en & same_lvl & st_allint;
    blk_sp        = nmi_en & spm_en & same_lvl & st_sp;
    free_of_super = ~(blk_all | blk_sp);
  end

  generate
    if (IS_SUPER) begin : g_super
      // without the level's enable a superpriority request behaves like IRQ
      assign ok = pend & reachable & free_of_super & (nmi_en | ~st_i);
    end else if (USE_F) begin : g_fiq
      assign ok = pend & reachable & free_of_super & ~st_f;
    end else begin : g_irq
      assign ok = pend & reachable & free_of_super & ~st_i;
    end
  endgenerate
endmodule

// File: rtl/irqarb_prio.sv
module irqarb_prio
  import irqarb_pkg::*;
(
  input  logic [NLINES-1:0] ok,
  output logic [NLINES-1:0] grant,
  output kind_e             kind
);
  always_comb begin
    grant = '0;
    kind  = K_NONE;
    for (int r = NLINES - 1; r >= 0; r--) begin
      if (ok[line_at_rank(r)]) begin
        grant = '0;
        grant[line_at_rank(r)] = 1'b1;
        kind  = kind_of_line(line_at_rank(r));
      end
    end
  end
endmodule

// File: rtl/irq_superprio_arb.sv
module irq_superprio_arb
  import irqarb_pkg::*;
#(
  parameter int LVL_W = 2,
  localparam int NLVL = 1 << LVL_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NLINES-1:0]       req_i,
  input  logic                    vserr_i,
  input  logic                    pwr_off_i,
  input  logic [LVL_W-1:0]        cur_lvl_i,
  input  logic [NLINES*LVL_W-1:0] line_tgt_i,
  input  logic [NLVL-1:0]         nmi_en_i,
  input  logic [NLVL-1:0]         spmask_en_i,
  input  logic                    st_i_i,
  input  logic                    st_f_i,
  input  logic                    st_allint_i,
  input  logic                    st_sp_i,
  output logic                    take_o,
  output logic [2:0]              kind_o,
  output logic [LVL_W-1:0]        tgt_o,
  output logic                    has_work_o
);
  logic [NLINES-1:0] ok;
  logic [NLINES-1:0] grant;
  kind_e             win_kind;
  logic [LVL_W-1:0]  win_tgt;

  generate
    for (genvar k = 0; k < NLINES; k++) begin : g_line
      logic [LVL_W-1:0] t;
      assign t = line_tgt_i[k*LVL_W +: LVL_W];
      irqarb_gate #(
        .LVL_W   (LVL_W),
        .IS_SUPER(line_is_super(k)),
        .USE_F   (line_uses_f(k))
      ) u_gate (
        .pend     (req_i[k]),
        .cur      (cur_lvl_i),
        .tgt      (t),
        .nmi_en   (nmi_en_i[t]),
        .spm_en   (spmask_en_i[t]),
        .st_i     (st_i_i),
        .st_f     (st_f_i),
        .st_allint(st_allint_i),
        .st_sp    (st_sp_i),
        .ok       (ok[k])
      );
    end
  endgenerate

  irqarb_prio u_prio (
    .ok   (ok),
    .grant(grant),
    .kind (win_kind)
  );

  always_comb begin
    win_tgt = '0;
    for (int k = 0; k < NLINES; k++)
      if (grant[k]) win_tgt = line_tgt_i[k*LVL_W +: LVL_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      take_o     <= 1'b0;
      kind_o     <= 3'd0;
      tgt_o      <= '0;
      has_work_o <= 1'b0;
    end else begin
      take_o     <= (win_kind != K_NONE) && (win_kind != kind_e'(kind_o));
      kind_o     <= win_kind;
      tgt_o      <= win_tgt;
      has_work_o <= ~pwr_off_i & ((|req_i) | vserr_i);
    end
  end
endmodule

// File: rtl/irqarb_chk.sv
module irqarb_chk #(
  parameter int LVL_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic [5:0]       req,
  input logic             vserr,
  input logic             pwr_off,
  input logic [LVL_W-1:0] cur,
  input logic             st_f,
  input logic [5:0]       grant,
  input logic             take,
  input logic [2:0]       kind,
  input logic [LVL_W-1:0] tgt,
  input logic             has_work
);
  // R8
  grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  // R3
  lower_target_chk: assert property (@(posedge clk) disable iff (rst)
    take |-> (tgt >= $past(cur)));

  // R9
  take_new_chk: assert property (@(posedge clk) disable iff (rst)
    take |-> (kind != 3'd0) && (kind != $past(kind)));

  // R7
  fiq_fmask_chk: assert property (@(posedge clk) disable iff (rst)
    (take && kind == 3'd2) |-> !$past(st_f));

  // R10
  has_work_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (has_work == $past(!pwr_off && ((|req) || vserr))));
endmodule

bind irq_superprio_arb irqarb_chk #(.LVL_W(LVL_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .req     (req_i),
  .vserr   (vserr_i),
  .pwr_off (pwr_off_i),
  .cur     (cur_lvl_i),
  .st_f    (st_f_i),
  .grant   (grant),
  .take    (take_o),
  .kind    (kind_o),
  .tgt     (tgt_o),
  .has_work(has_work_o)
);

// File: tb/sim_irq_superprio_arb.sv
`timescale 1ns/1ps
module sim_irq_superprio_arb;
  localparam int LW = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  req = '0;
  logic        vserr = 1'b0, pwr_off = 1'b0;
  logic [1:0]  cur = '0;
  logic [11:0] tgt = '0;
  logic [3:0]  nctl = '0, sctl = '0;
  logic        si = 1'b0, sf = 1'b0, sa = 1'b0, ssp = 1'b0;
  logic        take;
  logic [2:0]  kind;
  logic [1:0]  tgo;
  logic        hw;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_superprio_arb #(.LVL_W(LW)) u0 (
    .clk(clk), .rst(rst), .req_i(req), .vserr_i(vserr), .pwr_off_i(pwr_off),
    .cur_lvl_i(cur), .line_tgt_i(tgt), .nmi_en_i(nctl), .spmask_en_i(sctl),
    .st_i_i(si), .st_f_i(sf), .st_allint_i(sa), .st_sp_i(ssp),
    .take_o(take), .kind_o(kind), .tgt_o(tgo), .has_work_o(hw)
  );

  // reference from the requirements: returns {target, kind}
  function automatic logic [4:0] model();
    logic [5:0] okv;
    int order[6];
    logic [2:0] kcode[6];
    order = '{4, 5, 1, 0, 3, 2};
    kcode = '{3'd3, 3'd2, 3'd6, 3'd5, 3'd1, 3'd4};
    for (int k = 0; k < 6; k++) begin
      logic [1:0] t;
      logic blocked, classic;
      t = tgt[2*k +: 2];
      blocked = (t == cur) && nctl[t] && (sa || (sctl[t] && ssp));
      if (k == 4 || k == 5) classic = nctl[t] ? 1'b1 : !si;
      else if (k == 1 || k == 3) classic = !sf;
      else classic = !si;
      okv[k] = req[k] && (t >= cur) && !blocked && classic;
    end
    for (int r = 0; r < 6; r++)
      if (okv[order[r]]) return {tgt[2*order[r] +: 2], kcode[order[r]]};
    return 5'd0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  logic [2:0] prev_k = '0;

  // inputs are already driven; one edge, then compare
  task automatic step_and_check();
    logic [4:0] m;
    logic       ehw;
    m   = model();
    ehw = !pwr_off && ((|req) || vserr);
    @(posedge clk); #1;
    chk("R2 R3 R4 R5 R6 R7 R8 kind", kind, m[2:0]);
    chk("R11 target", tgo, m[4:3]);
    chk("R9 take", take, (m[2:0] != 0) && (m[2:0] != prev_k));
    chk("R10 has_work", hw, ehw);
    prev_k = m[2:0];
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    req = 6'h3f; vserr = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset kind", kind, 0);
    chk("R1 reset take", take, 0);
    chk("R1 reset tgt", tgo, 0);
    chk("R1 reset has_work", hw, 0);
    @(negedge clk); rst = 1'b0; req = '0; vserr = 1'b0;
    @(posedge clk); #1;
    chk("R1 first cycle kind", kind, 0);
    chk("R1 first cycle has_work", hw, 0);

    // directed: NMI at current level, superpriority on, I and F set -> taken (R6)
    @(negedge clk);
    cur = 2'd1; tgt = {6{2'd1}}; nctl = 4'b0010; sctl = 4'b0000;
    si = 1; sf = 1; sa = 0; ssp = 0; req = 6'b010011;
    @(posedge clk); #1;
    chk("R6 nmi bypasses I/F", kind, 3'd1);
    chk("R9 take on new winner", take, 1);
    @(posedge clk); #1;
    chk("R9 take single pulse", take, 0);
    // ALLINT now blocks it (R4)
    @(negedge clk); sa = 1;
    @(posedge clk); #1;
    chk("R4 allint blocks same-level nmi", kind, 3'd0);
    // superpriority off at that level: I masks NMI like IRQ (R6)
    @(negedge clk); sa = 0; nctl = 4'b0000;
    @(posedge clk); #1;
    chk("R6 nmi masked by I when disabled", kind, 3'd0);
    prev_k = 3'd0;

    // sweep
    for (int p = 0; p < 4; p++) begin
      for (int c = 0; c < 4; c++) begin
        for (int s = 0; s < 16; s++) begin
          for (int r = 0; r < 64; r++) begin
            @(negedge clk);
            for (int k = 0; k < 6; k++) tgt[2*k +: 2] = 2'((k + p + (r >> 5)) & 3);
            case (p)
              0: begin nctl = 4'b0000; sctl = 4'b1111; end
              1: begin nctl = 4'b1111; sctl = 4'b1111; end
              2: begin nctl = 4'b1010; sctl = 4'b0011; end
              default: begin nctl = 4'b0110; sctl = 4'b1100; end
            endcase
            cur = 2'(c);
            {si, sf, sa, ssp} = 4'(s);
            req = 6'(r);
            pwr_off = (p[0] & c[0]);
            vserr = s[0] ^ c[1];
            step_and_check();
          end
        end
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule